// File: doc/BRIEF.md
# Clock-Slave Synchronous Serial Transmitter

This block sends words out on a serial data line, one bit for each rising edge of a shift clock that an external master drives. The host sees four byte-wide registers: a transmit control register, a port control register, a data register and an interrupt-enable register. A word written to the data register goes into a one-deep holding stage. From there it moves into the shift register as soon as that register is free and the transmitter is active.

The shift clock reaches the block from outside. It passes through a two-flop synchronizer, and an edge detector then finds each low-to-high transition. Bits leave least significant first. In 9-bit framing a ninth bit follows the eight data bits. A holding-empty flag and a shift-empty status bit report progress, and an interrupt request follows the flag when both enables are set.

Register map (address, then the bits that matter). Address 0, transmit control: bit 7 clock master, bit 6 nine-bit framing, bit 5 transmit enable, bit 4 synchronous mode, bit 1 shift-empty (read only), bit 0 ninth data bit. Address 1, port control: bit 7 port enable, bit 5 single receive, bit 4 continuous receive, bit 3 address detect. Address 2: a write loads the holding stage, and a read returns {wcol, shift-empty, holding-empty flag} in bits 2..0. Address 3: bit 0 transmit interrupt enable, bit 1 peripheral interrupt enable, and writing 1 to bit 7 clears wcol. Reads return one cycle after the address is presented.

Top module: `sst_slave_tx`

## Requirements
- R1: After reset, address 0 reads 0x02 and address 2 reads 0x02, with sdo_oe and irq low.
- R2: The transmitter is active only while synchronous mode is 1, clock master is 0, port enable is 1, and both receive enables are 0. While it is inactive, no word leaves the holding stage and sdo_oe is low.
- R3: A word written while the shift register is empty and the transmitter is active loads into the shift register on the next cycle. The holding-empty flag sets at that load.
- R4: A word written while a shift is in progress waits in the holding stage, and the flag stays low meanwhile. The word loads and the flag sets only after the last bit of the current word has been driven.
- R5: Each synchronized rising edge of sclk drives the next bit on sdo, least significant bit first. Each bit appears within three system clocks of the edge.
- R6: With nine-bit framing set, a ninth bit follows the eight data bits. Its value is control bit 0 as it stood when the data register was written.
- R7: irq equals flag AND transmit interrupt enable AND peripheral interrupt enable, registered one cycle.
- R8: The address-detect bit has no effect on transmission.
- R9: sdo_oe is low whenever transmit enable or port enable is 0. Clearing transmit enable aborts a shift in progress and sets shift-empty.
- R10: A write to the data register while the holding stage is full is dropped and sets the sticky wcol bit. Writing 1 to bit 7 of address 3 clears wcol.
- R11: A write to the data register clears the holding-empty flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Registered read data for bus_addr |
| sclk | input | 1 | Shift clock from the external master (asynchronous) |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| irq | output | 1 | Transmit interrupt request |

## Verification
The assertions assume that sclk is slow against the system clock: each high and low phase lasts at least three system clocks, so the synchronizer never misses an edge. They also assume that the host never writes the data register when the mode bits block transmission, unless it intends that word to wait. The bench keeps sclk at five system clocks high and four low. It pulses sclk only as many times as there are bits queued in its scoreboard, except in the abort case, where it deliberately leaves a word unfinished.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int REG_TCTL = 0;
  localparam int REG_PCTL = 1;
  localparam int REG_DATA = 2;
  localparam int REG_IEN  = 3;

  typedef struct packed {
    logic clk_master;
    logic nine_sel;
    logic tx_en;
    logic sync_sel;
    logic d9;
  } tx_ctrl_t;

  typedef struct packed {
    logic port_en;
    logic rx_single;
    logic rx_cont;
    logic addr_det;
  } port_ctrl_t;
endpackage

// File: rtl/sst_sync.sv
module sst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], async_in};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/sst_holdbuf.sv
module sst_holdbuf #(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [DATA_W:0] wword,
  input  logic            wnine,
  input  logic            take,
  input  logic            wcol_clr,
  output logic            full,
  output logic [DATA_W:0] word,
  output logic            nine,
  output logic            flag,
  output logic            wcol
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      word <= '0;
      nine <= 1'b0;
      flag <= 1'b0;
      wcol <= 1'b0;
    end else begin
      if (take) begin
        full <= 1'b0;
        flag <= 1'b1;
      end
      if (wcol_clr) wcol <= 1'b0;
      if (wr) begin
        if (full && !take) begin
          wcol <= 1'b1;
        end else begin
          full <= 1'b1;
          word <= wword;
          nine <= wnine;
          flag <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter #(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            active,
  input  logic            rise,
  input  logic            hold_full,
  input  logic [DATA_W:0] word,
  input  logic            nine,
  output logic            take,
  output logic            sdo,
  output logic            empty
);
  localparam int CNT_W = $clog2(DATA_W + 2);

  logic [DATA_W:0] sr;
  logic [CNT_W-1:0] cnt;

  assign empty = (cnt == '0);
  assign take  = active && empty && hold_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      cnt <= '0;
      sdo <= 1'b0;
    end else if (!active) begin
      cnt <= '0;
    end else if (take) begin
      sr  <= word;
      cnt <= nine ? CNT_W'(DATA_W + 1) : CNT_W'(DATA_W);
    end else if (rise && !empty) begin
      sdo <= sr[0];
      sr  <= sr >> 1;
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/sst_slave_tx.sv
module sst_slave_tx
  import sst_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sclk,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              irq
);
  tx_ctrl_t   tctl;
  port_ctrl_t pctl;
  logic       txie, peie;
  logic       tx_act, rise, take, hold_full, hold_nine, flag, wcol, sr_empty;
  logic       ie_ok, data_wr, wcol_clr;
  logic [DATA_W:0] hold_word;
  logic [7:0] rd_byte;

  assign tx_act = tctl.sync_sel & ~tctl.clk_master & tctl.tx_en &
                  pctl.port_en & ~pctl.rx_cont & ~pctl.rx_single;
  assign ie_ok    = txie & peie;
  assign data_wr  = bus_wr && (int'(bus_addr) == REG_DATA);
  assign wcol_clr = bus_wr && (int'(bus_addr) == REG_IEN) && bus_wdata[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      tctl <= '0;
      pctl <= '0;
      txie <= 1'b0;
      peie <= 1'b0;
    end else if (bus_wr) begin
      case (int'(bus_addr))
        REG_TCTL: tctl <= '{clk_master: bus_wdata[7], nine_sel: bus_wdata[6],
                            tx_en: bus_wdata[5], sync_sel: bus_wdata[4],
                            d9: bus_wdata[0]};
        REG_PCTL: pctl <= '{port_en: bus_wdata[7], rx_single: bus_wdata[5],
                            rx_cont: bus_wdata[4], addr_det: bus_wdata[3]};
        REG_IEN: begin
          txie <= bus_wdata[0];
          peie <= bus_wdata[1];
        end
        default: ;
      endcase
    end
  end

  sst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(sclk), .rise(rise)
  );

  sst_holdbuf #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .wr(data_wr), .wword({tctl.d9, bus_wdata}),
    .wnine(tctl.nine_sel), .take(take), .wcol_clr(wcol_clr),
    .full(hold_full), .word(hold_word), .nine(hold_nine),
    .flag(flag), .wcol(wcol)
  );

  sst_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .active(tx_act), .rise(rise),
    .hold_full(hold_full), .word(hold_word), .nine(hold_nine),
    .take(take), .sdo(sdo), .empty(sr_empty)
  );

  always_comb begin
    case (int'(bus_addr))
      REG_TCTL: rd_byte = {tctl.clk_master, tctl.nine_sel, tctl.tx_en,
                           tctl.sync_sel, 2'b00, sr_empty, tctl.d9};
      REG_PCTL: rd_byte = {pctl.port_en, 1'b0, pctl.rx_single, pctl.rx_cont,
                           pctl.addr_det, 3'b000};
      REG_DATA: rd_byte = {5'b0, wcol, sr_empty, flag};
      default:  rd_byte = {6'b0, peie, txie};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      sdo_oe    <= 1'b0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= DATA_W'(rd_byte);
      sdo_oe    <= tx_act;
      irq       <= flag & ie_ok;
    end
  end
endmodule

// File: rtl/sst_slave_tx_chk.sv
module sst_slave_tx_chk (
  input logic clk,
  input logic rst,
  input logic tx_act,
  input logic hold_full,
  input logic flag,
  input logic sr_empty,
  input logic sdo_oe,
  input logic irq,
  input logic ie_ok
);
  p_oe_off_r9: assert property (@(posedge clk) disable iff (rst)
    !tx_act |=> !sdo_oe);
  p_oe_on_r2: assert property (@(posedge clk) disable iff (rst)
    tx_act |=> sdo_oe);
  p_abort_empty_r9: assert property (@(posedge clk) disable iff (rst)
    !tx_act |=> sr_empty);
  p_direct_load_r3: assert property (@(posedge clk) disable iff (rst)
    (tx_act && sr_empty && hold_full) |=> !sr_empty);
  p_flag_low_waiting_r4: assert property (@(posedge clk) disable iff (rst)
    hold_full |-> !flag);
  p_flag_on_load_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(hold_full) && !hold_full);
  p_irq_follows_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(flag && ie_ok));
endmodule

bind sst_slave_tx sst_slave_tx_chk u_chk (
  .clk(clk), .rst(rst), .tx_act(tx_act), .hold_full(hold_full),
  .flag(flag), .sr_empty(sr_empty), .sdo_oe(sdo_oe), .irq(irq),
  .ie_ok(ie_ok)
);

// File: tb/test_sst_slave_tx.sv
`timescale 1ns/1ps
module test_sst_slave_tx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       sclk = 1'b0;
  logic       sdo, sdo_oe, irq;

  int n_chk = 0;
  int n_fail = 0;
  logic exp_q[$];

  always #2 clk = ~clk;

  sst_slave_tx i_sst_slave_tx (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk),
    .sdo(sdo), .sdo_oe(sdo_oe), .irq(irq)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    repeat (3) @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic push_word(logic [8:0] w, int nbits);
    for (int i = 0; i < nbits; i++) exp_q.push_back(w[i]);
  endtask

  // monitor side: one shift-clock pulse, compare the bit against the queue
  task automatic pulse(bit do_check, string tag);
    logic e;
    @(negedge clk);
    sclk = 1'b1;
    repeat (5) @(negedge clk);
    if (do_check) begin
      if (exp_q.size() == 0) begin
        check({tag, " queue empty"}, 8'd1, 8'd0);
      end else begin
        e = exp_q.pop_front();
        check(tag, {7'b0, sdo}, {7'b0, e});
      end
    end
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulses(int n, string tag);
    for (int i = 0; i < n; i++) pulse(1'b1, tag);
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle(1);
    // R1 reset state
    check("R1 sdo_oe", {7'b0, sdo_oe}, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    rd_reg(2'd0, r); check("R1 tctl", r, 8'h02);
    rd_reg(2'd2, r); check("R1 status", r, 8'h02);

    // configure: port enable plus address detect (R8), both interrupt enables
    wr_reg(2'd1, 8'h88);
    wr_reg(2'd3, 8'h03);
    wr_reg(2'd0, 8'h30);
    settle(2);
    check("R2 oe active", {7'b0, sdo_oe}, 8'h01);

    // R3 first write loads at once, R11/R7
    wr_reg(2'd2, 8'hA5); push_word(9'h0A5, 8);
    rd_reg(2'd2, r); check("R3 status after direct load", r, 8'h01);
    check("R7 irq on flag", {7'b0, irq}, 8'h01);

    // R4 second write waits, R10 third write collides
    wr_reg(2'd2, 8'h3C); push_word(9'h03C, 8);
    rd_reg(2'd2, r); check("R4 R11 flag low while waiting", r, 8'h00);
    check("R7 irq low", {7'b0, irq}, 8'h00);
    wr_reg(2'd2, 8'hFF);
    rd_reg(2'd2, r); check("R10 wcol set", r, 8'h04);

    pulses(7, "R5 R8 bit of A5");
    rd_reg(2'd2, r); check("R4 flag low before last bit", r, 8'h04);
    pulses(1, "R5 last bit of A5");
    rd_reg(2'd2, r); check("R4 flag after second load", r, 8'h05);
    pulses(8, "R5 R10 bit of 3C (FF dropped)");
    rd_reg(2'd2, r); check("R4 shift empty", r, 8'h07);
    wr_reg(2'd3, 8'h83);
    rd_reg(2'd2, r); check("R10 wcol cleared", r, 8'h03);

    // R6 nine-bit framing, ninth bit captured at write time
    wr_reg(2'd0, 8'h71);
    wr_reg(2'd2, 8'h0F); push_word(9'h10F, 9);
    wr_reg(2'd0, 8'h70);
    pulses(9, "R6 nine-bit frame");
    rd_reg(2'd2, r); check("R6 done", r, 8'h03);
    wr_reg(2'd0, 8'h30);

    // R7 peripheral enable low masks irq
    wr_reg(2'd3, 8'h01); settle(2);
    check("R7 irq masked", {7'b0, irq}, 8'h00);
    wr_reg(2'd3, 8'h03); settle(2);
    check("R7 irq unmasked", {7'b0, irq}, 8'h01);

    // R2 receive enable blocks transmission
    wr_reg(2'd1, 8'h90); settle(2);
    check("R2 oe off in receive", {7'b0, sdo_oe}, 8'h00);
    wr_reg(2'd2, 8'h55);
    pulse(1'b0, "");
    rd_reg(2'd2, r); check("R2 no load while gated", r, 8'h02);
    wr_reg(2'd1, 8'h80); push_word(9'h055, 8);
    rd_reg(2'd2, r); check("R2 load after ungate", r, 8'h01);
    check("R2 oe back on", {7'b0, sdo_oe}, 8'h01);
    pulses(8, "R5 bit of 55");
    wr_reg(2'd0, 8'hB0); settle(2);
    check("R2 oe off as clock master", {7'b0, sdo_oe}, 8'h00);
    wr_reg(2'd0, 8'h30); settle(2);

    // R9 abort mid-word
    wr_reg(2'd2, 8'h81);
    for (int i = 0; i < 3; i++) pulse(1'b0, "");
    rd_reg(2'd0, r); check("R9 busy before abort", r, 8'h30);
    wr_reg(2'd0, 8'h10); settle(2);
    check("R9 oe off tx disabled", {7'b0, sdo_oe}, 8'h00);
    rd_reg(2'd2, r); check("R9 shift empty after abort", r, 8'h03);
    wr_reg(2'd0, 8'h30); wr_reg(2'd1, 8'h00); settle(2);
    check("R9 oe off port disabled", {7'b0, sdo_oe}, 8'h00);

    check("R5 scoreboard drained", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule